// File: doc/BRIEF.md
# Boot-Shadowing Address Decoder

This block turns each bus cycle of a CPU with a 24-bit address bus and 3-bit function-code lines into one chip select out of three: RAM, a byte-wide flash, or the I/O area. The whole 16 MB space belongs to RAM unless an address falls in one of the carved-out holes. The holes are a 64 KB boot window at the bottom of the map, a 64 KB paged flash window and a 64 KB I/O area at the top. The decoder also returns the port width of the selected device, so the CPU can size its bus dynamically.

At start-up the boot window reads from flash page 0, which supplies the reset vectors. Writes to the same addresses land in RAM, so firmware can copy the boot code into RAM by reading and writing each location. It then sets a shadow bit, and after that both reads and writes in the boot window go to RAM. Beyond the boot area, flash is reached through the paged window, and an 8-bit page register picks which 64 KB page it shows. A cycle with the spare function code 3 reaches flash directly, at a flash offset equal to the bus address, without touching the normal map. The page register and the shadow bit sit at the top of the I/O area, and the decoder captures them from ordinary write cycles.

Top module: `boot_shadow_decoder`

## Requirements
- R1: While `as_n` is high, or while `fc` is 7 (CPU space), no chip select is asserted and `flash_addr` is 0.
- R2: A valid cycle to an address outside every hole asserts `cs_ram` and gives `port_size` 2'b00, meaning 32 bits.
- R3: An address from 0xFF0000 to 0xFFFFFF asserts `cs_io` and gives `port_size` 2'b10, meaning 16 bits.
- R4: An address from 0xFE0000 to 0xFEFFFF asserts `cs_flash` with `port_size` 2'b01 (8 bits), and `flash_addr` = {page, addr[15:0]}.
- R5: The page register resets to 0. A valid write to 0xFFFF00 loads it from `wdata`, and the new value applies from the next cycle on.
- R6: With shadowing off, a read from 0x000000 to 0x00FFFF asserts `cs_flash` (8-bit) at `flash_addr` = {8'h00, addr[15:0]}, and a write to that range asserts `cs_ram` (32-bit).
- R7: The shadow bit resets to 0. A valid write to 0xFFFF01 loads it from `wdata[0]`. While it is 1, both reads and writes to 0x000000 to 0x00FFFF assert `cs_ram`.
- R8: A cycle with `fc` = 3 asserts `cs_flash` (8-bit) at `flash_addr` = addr, whatever the address, the page and the shadow bit are. Such a cycle never writes the page register or the shadow bit.
- R9: Every cycle with `as_n` low and `fc` other than 7 asserts exactly one chip select.
- R10: Register state changes only on cycles with `as_n` low, `rw` low and `fc` neither 3 nor 7. Reads of the register addresses leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code |
| addr | input | 24 | Byte address |
| wdata | input | 8 | Byte lane used for register writes |
| cs_ram | output | 1 | RAM select |
| cs_flash | output | 1 | Flash select |
| cs_io | output | 1 | I/O select |
| port_size | output | 2 | 00 = 32-bit, 01 = 8-bit, 10 = 16-bit |
| flash_addr | output | 24 | Byte offset into flash |

## Verification
Directed cycles probe the edges of every hole, one address inside and one outside each boundary. Writes and reads to the boot window, taken both before and after shadowing, tell the read-only flash overlay apart from full RAM mapping. Register writes under a high strobe, under read, and under function code 3 each show that only a proper write cycle changes the page or shadow state, and the paged-window address reveals which page is active. Seeded random cycles mix all regions, function codes and directions, so that priority between the function-code path and the address holes is exercised against a bench model.

// File: rtl/bsd_pkg.sv
// Shared encodings for the boot-shadowing decoder.
// Assumes a three-device map: RAM, byte-wide flash, I/O.
package bsd_pkg;
    // Port width reported back to the CPU for dynamic bus sizing.
    typedef enum logic [1:0] {
        PS_32 = 2'b00,
        PS_8  = 2'b01,
        PS_16 = 2'b10
    } port_size_e;

    // Which decode path claimed the current cycle.
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_FLASH_FC,
        TGT_FLASH_PAGE,
        TGT_FLASH_BOOT,
        TGT_IO
    } target_e;
endpackage

// File: rtl/bsd_window_match.sv
// Compares the upper address bits (the tag) against a fixed window base.
// Assumes windows are aligned to their own size.
module bsd_window_match #(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned BASE  = 0
) (
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    localparam logic [TAG_W-1:0] BASE_L = TAG_W'(BASE);

    // Window hit on exact tag equality.
    always_comb hit = (tag == BASE_L);
endmodule

// File: rtl/bsd_ctrl_regs.sv
// Holds the flash page register and the shadow enable bit.
// Captures them from ordinary write cycles to two offsets inside the I/O hole.
// Assumes register writes are idempotent if the strobe spans several clocks.
module bsd_ctrl_regs #(
    parameter int unsigned FC_W       = 3,
    parameter int unsigned WIN_BITS   = 16,
    parameter int unsigned PAGE_W     = 8,
    parameter int unsigned PAGE_OFF   = 16'hFF00,
    parameter int unsigned CTRL_OFF   = 16'hFF01,
    parameter int unsigned FC_FLASH   = 3,
    parameter int unsigned FC_CPU     = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                as_n,
    input  logic                rw,
    input  logic [FC_W-1:0]     fc,
    input  logic                io_hit,
    input  logic [WIN_BITS-1:0] offset,
    input  logic [PAGE_W-1:0]   wdata,
    output logic [PAGE_W-1:0]   page_q,
    output logic                shadow_q
);
    localparam logic [WIN_BITS-1:0] PAGE_OFF_L = WIN_BITS'(PAGE_OFF);
    localparam logic [WIN_BITS-1:0] CTRL_OFF_L = WIN_BITS'(CTRL_OFF);
    localparam logic [FC_W-1:0]     FC_FLASH_L = FC_W'(FC_FLASH);
    localparam logic [FC_W-1:0]     FC_CPU_L   = FC_W'(FC_CPU);

    logic wr_cycle;
    logic wr_page;
    logic wr_ctrl;

    // A write cycle that belongs to the normal data map.
    always_comb begin
        wr_cycle = !as_n && !rw && (fc != FC_FLASH_L) && (fc != FC_CPU_L) && io_hit;
        wr_page  = wr_cycle && (offset == PAGE_OFF_L);
        wr_ctrl  = wr_cycle && (offset == CTRL_OFF_L);
    end

    // Page register update.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (wr_page) page_q <= wdata;
    end

    // Shadow enable update.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= 1'b0;
        else if (wr_ctrl) shadow_q <= wdata[0];
    end

    assert_page_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !rw && fc != FC_FLASH_L && fc != FC_CPU_L && io_hit && offset == PAGE_OFF_L)
        |=> (page_q == $past(wdata)));

    assert_shadow_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !rw && fc != FC_FLASH_L && fc != FC_CPU_L && io_hit && offset == CTRL_OFF_L)
        |=> (shadow_q == $past(wdata[0])));

    assert_hold_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n || rw || fc == FC_FLASH_L || fc == FC_CPU_L)
        |=> ($stable(page_q) && $stable(shadow_q)));
endmodule

// File: rtl/bsd_select.sv
// Picks one target per cycle by fixed priority and forms the chip selects,
// the port size and the flash byte offset.
// Priority: CPU space, function-code flash, I/O, paged window, boot overlay, RAM.
module bsd_select
    import bsd_pkg::*;
#(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned FC_W     = 3,
    parameter int unsigned WIN_BITS = 16,
    parameter int unsigned PAGE_W   = 8,
    parameter int unsigned FC_FLASH = 3,
    parameter int unsigned FC_CPU   = 7,
    localparam int unsigned FLASH_AW = PAGE_W + WIN_BITS
) (
    input  logic                as_n,
    input  logic                rw,
    input  logic [FC_W-1:0]     fc,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                boot_hit,
    input  logic                page_hit,
    input  logic                io_hit,
    input  logic [PAGE_W-1:0]   page_q,
    input  logic                shadow_q,
    output logic                cs_ram,
    output logic                cs_flash,
    output logic                cs_io,
    output logic [1:0]          port_size,
    output logic [FLASH_AW-1:0] flash_addr
);
    localparam logic [FC_W-1:0] FC_FLASH_L = FC_W'(FC_FLASH);
    localparam logic [FC_W-1:0] FC_CPU_L   = FC_W'(FC_CPU);

    target_e             tgt;
    logic [FLASH_AW-1:0] fc_addr;

    // Direct flash offset for function-code cycles, sized to the flash.
    generate
        if (FLASH_AW <= ADDR_W) begin : g_fc_trunc
            assign fc_addr = addr[FLASH_AW-1:0];
        end else begin : g_fc_extend
            assign fc_addr = {{(FLASH_AW-ADDR_W){1'b0}}, addr};
        end
    endgenerate

    // Priority decode of the current cycle.
    always_comb begin
        tgt = TGT_NONE;
        if (!as_n && fc != FC_CPU_L) begin
            if (fc == FC_FLASH_L)                tgt = TGT_FLASH_FC;
            else if (io_hit)                     tgt = TGT_IO;
            else if (page_hit)                   tgt = TGT_FLASH_PAGE;
            else if (boot_hit && rw && !shadow_q) tgt = TGT_FLASH_BOOT;
            else                                 tgt = TGT_RAM;
        end
    end

    // Chip selects, port size and flash offset per target.
    always_comb begin
        cs_ram     = 1'b0;
        cs_flash   = 1'b0;
        cs_io      = 1'b0;
        port_size  = PS_32;
        flash_addr = '0;
        case (tgt)
            TGT_RAM: begin
                cs_ram    = 1'b1;
                port_size = PS_32;
            end
            TGT_IO: begin
                cs_io     = 1'b1;
                port_size = PS_16;
            end
            TGT_FLASH_FC: begin
                cs_flash   = 1'b1;
                port_size  = PS_8;
                flash_addr = fc_addr;
            end
            TGT_FLASH_PAGE: begin
                cs_flash   = 1'b1;
                port_size  = PS_8;
                flash_addr = {page_q, addr[WIN_BITS-1:0]};
            end
            TGT_FLASH_BOOT: begin
                cs_flash   = 1'b1;
                port_size  = PS_8;
                flash_addr = {{PAGE_W{1'b0}}, addr[WIN_BITS-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/boot_shadow_decoder.sv
// Top of the boot-shadowing address decoder.
// Splits the address into window tags, runs the register block and the
// target select, and checks the chip-select rules at the ports.
// Assumes inputs are stable around the rising clock edge.
module boot_shadow_decoder #(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned FC_W      = 3,
    parameter int unsigned WIN_BITS  = 16,
    parameter int unsigned PAGE_W    = 8,
    parameter int unsigned BOOT_TAG  = 8'h00,
    parameter int unsigned PAGE_TAG  = 8'hFE,
    parameter int unsigned IO_TAG    = 8'hFF,
    parameter int unsigned PAGE_OFF  = 16'hFF00,
    parameter int unsigned CTRL_OFF  = 16'hFF01,
    parameter int unsigned FC_FLASH  = 3,
    parameter int unsigned FC_CPU    = 7,
    localparam int unsigned TAG_W    = ADDR_W - WIN_BITS,
    localparam int unsigned FLASH_AW = PAGE_W + WIN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                as_n,
    input  logic                rw,
    input  logic [FC_W-1:0]     fc,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PAGE_W-1:0]   wdata,
    output logic                cs_ram,
    output logic                cs_flash,
    output logic                cs_io,
    output logic [1:0]          port_size,
    output logic [FLASH_AW-1:0] flash_addr
);
    import bsd_pkg::*;

    localparam logic [FC_W-1:0] FC_CPU_L = FC_W'(FC_CPU);

    logic              boot_hit;
    logic              page_hit;
    logic              io_hit;
    logic [PAGE_W-1:0] page_q;
    logic              shadow_q;

    // One comparator per carved-out window.
    bsd_window_match #(.TAG_W(TAG_W), .BASE(BOOT_TAG)) u_boot_win (
        .tag(addr[ADDR_W-1:WIN_BITS]), .hit(boot_hit));
    bsd_window_match #(.TAG_W(TAG_W), .BASE(PAGE_TAG)) u_page_win (
        .tag(addr[ADDR_W-1:WIN_BITS]), .hit(page_hit));
    bsd_window_match #(.TAG_W(TAG_W), .BASE(IO_TAG)) u_io_win (
        .tag(addr[ADDR_W-1:WIN_BITS]), .hit(io_hit));

    bsd_ctrl_regs #(
        .FC_W(FC_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W),
        .PAGE_OFF(PAGE_OFF), .CTRL_OFF(CTRL_OFF),
        .FC_FLASH(FC_FLASH), .FC_CPU(FC_CPU)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .fc(fc),
        .io_hit(io_hit), .offset(addr[WIN_BITS-1:0]), .wdata(wdata),
        .page_q(page_q), .shadow_q(shadow_q)
    );

    bsd_select #(
        .ADDR_W(ADDR_W), .FC_W(FC_W), .WIN_BITS(WIN_BITS), .PAGE_W(PAGE_W),
        .FC_FLASH(FC_FLASH), .FC_CPU(FC_CPU)
    ) u_sel (
        .as_n(as_n), .rw(rw), .fc(fc), .addr(addr),
        .boot_hit(boot_hit), .page_hit(page_hit), .io_hit(io_hit),
        .page_q(page_q), .shadow_q(shadow_q),
        .cs_ram(cs_ram), .cs_flash(cs_flash), .cs_io(cs_io),
        .port_size(port_size), .flash_addr(flash_addr)
    );

    assert_idle_no_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n || fc == FC_CPU_L) |-> ({cs_ram, cs_flash, cs_io} == 3'b000));

    assert_one_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc != FC_CPU_L) |-> ($countones({cs_ram, cs_flash, cs_io}) == 1));

    assert_ram_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ram |-> (port_size == PS_32));

    assert_io_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_io |-> (port_size == PS_16));

    assert_flash_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_flash |-> (port_size == PS_8));

    assert_io_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc != FC_CPU_L && fc != FC_W'(FC_FLASH) && io_hit) |-> cs_io);
endmodule

// File: tb/boot_shadow_decoder_tb.sv
module boot_shadow_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic [2:0]  fc = 3'd1;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        cs_ram, cs_flash, cs_io;
    logic [1:0]  port_size;
    logic [23:0] flash_addr;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] m_page = 8'h00;
    logic       m_shadow = 1'b0;
    bit         done = 1'b0;

    boot_shadow_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .fc(fc),
        .addr(addr), .wdata(wdata), .cs_ram(cs_ram), .cs_flash(cs_flash),
        .cs_io(cs_io), .port_size(port_size), .flash_addr(flash_addr)
    );

    always #5 clk = ~clk;

    // Expected {ram, flash, io, size[1:0], flash_addr[23:0]}.
    function automatic logic [28:0] expect_out(input logic a_n, input logic r,
                                               input logic [2:0] f, input logic [23:0] a);
        if (a_n || f == 3'd7)           return {3'b000, 2'b00, 24'h0};
        if (f == 3'd3)                  return {3'b010, 2'b01, a};
        if (a[23:16] == 8'hFF)          return {3'b001, 2'b10, 24'h0};
        if (a[23:16] == 8'hFE)          return {3'b010, 2'b01, m_page, a[15:0]};
        if (a[23:16] == 8'h00 && r && !m_shadow) return {3'b010, 2'b01, 8'h00, a[15:0]};
        return {3'b100, 2'b00, 24'h0};
    endfunction

    function automatic string tag_of(input logic a_n, input logic [2:0] f, input logic [23:0] a);
        if (a_n || f == 3'd7)  return "R1";
        if (f == 3'd3)         return "R8";
        if (a[23:16] == 8'hFF) return "R3";
        if (a[23:16] == 8'hFE) return "R4";
        if (a[23:16] == 8'h00) return m_shadow ? "R7" : "R6";
        return "R2";
    endfunction

    task automatic cmp(input string req);
        logic [28:0] exp_v, got_v;
        exp_v = expect_out(as_n, rw, fc, addr);
        got_v = {cs_ram, cs_flash, cs_io, port_size, flash_addr};
        n_vec++;
        if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%h fc=%0d rw=%b as_n=%b: got %h expected %h",
                     req, addr, fc, rw, as_n, got_v, exp_v);
        end
    endtask

    // Drive one cycle, check outputs mid-cycle, then update the model at the edge.
    task automatic apply(input logic a_n, input logic r, input logic [2:0] f,
                         input logic [23:0] a, input logic [7:0] wd, input string req);
        @(negedge clk);
        as_n = a_n; rw = r; fc = f; addr = a; wdata = wd;
        #1;
        cmp(req == "" ? tag_of(a_n, f, a) : req);
        if (!a_n && f != 3'd7) begin
            n_vec++;
            if ($countones({cs_ram, cs_flash, cs_io}) != 1) begin
                n_bad++;
                $display("FAIL R9 addr=%h: got cs=%b expected one-hot", a, {cs_ram, cs_flash, cs_io});
            end
        end
        @(posedge clk);
        if (!a_n && !r && f != 3'd3 && f != 3'd7) begin
            if (a == 24'hFFFF00) m_page = wd;
            if (a == 24'hFFFF01) m_shadow = wd[0];
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Reset state: boot read from flash page 0, page window on page 0 (R5, R6, R7)
        apply(0, 1, 3'd5, 24'h000000, 8'h00, "R7");
        apply(0, 1, 3'd5, 24'hFE1234, 8'h00, "R5");
        // R1: idle strobe and CPU space
        apply(1, 1, 3'd5, 24'h123456, 8'h00, "R1");
        apply(1, 0, 3'd5, 24'hFF0000, 8'h00, "R1");
        apply(0, 1, 3'd7, 24'hFFFFF0, 8'h00, "R1");
        // R2: RAM and the edges just outside the holes
        apply(0, 1, 3'd1, 24'h123456, 8'h00, "R2");
        apply(0, 1, 3'd5, 24'h010000, 8'h00, "R2");
        apply(0, 0, 3'd1, 24'hFDFFFF, 8'h00, "R2");
        // R3: I/O edges
        apply(0, 1, 3'd5, 24'hFF0000, 8'h00, "R3");
        apply(0, 1, 3'd5, 24'hFFFFFF, 8'h00, "R3");
        // R6: boot overlay edges and write-through to RAM
        apply(0, 1, 3'd6, 24'h00FFFF, 8'h00, "R6");
        apply(0, 0, 3'd5, 24'h000100, 8'h00, "R6");
        // R5: page load then window use
        apply(0, 0, 3'd5, 24'hFFFF00, 8'h5A, "R5");
        apply(0, 1, 3'd5, 24'hFE1234, 8'h00, "R5");
        apply(0, 1, 3'd5, 24'hFEFFFF, 8'h00, "R4");
        // R10: read, idle strobe, CPU space do not load the page
        apply(0, 1, 3'd5, 24'hFFFF00, 8'h33, "R10");
        apply(1, 0, 3'd5, 24'hFFFF00, 8'h44, "R10");
        apply(0, 0, 3'd7, 24'hFFFF00, 8'h55, "R10");
        apply(0, 1, 3'd5, 24'hFE0001, 8'h00, "R10");
        // R8: function-code flash; register write under fc 3 ignored
        apply(0, 0, 3'd3, 24'hFFFF00, 8'h77, "R8");
        apply(0, 1, 3'd5, 24'hFE0002, 8'h00, "R8");
        apply(0, 0, 3'd3, 24'hFFFF01, 8'h01, "R8");
        apply(0, 1, 3'd5, 24'h000004, 8'h00, "R8");
        // R7: shadow on, boot window all RAM; off again; on again
        apply(0, 0, 3'd5, 24'hFFFF01, 8'h01, "R7");
        apply(0, 1, 3'd5, 24'h000000, 8'h00, "R7");
        apply(0, 0, 3'd5, 24'h00FFFF, 8'h00, "R7");
        apply(0, 1, 3'd3, 24'h000010, 8'h00, "R8");
        apply(0, 0, 3'd5, 24'hFFFF01, 8'hFE, "R7");
        apply(0, 1, 3'd5, 24'h000020, 8'h00, "R7");
        apply(0, 0, 3'd5, 24'hFFFF01, 8'h01, "R7");

        // Seeded random mix across regions, codes and directions
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] a;
            logic [2:0]  f;
            int sel;
            sel = int'($urandom % 8);
            case (sel)
                0, 1: a = {8'h00, 16'($urandom)};
                2:    a = {8'hFE, 16'($urandom)};
                3:    a = {8'hFF, 16'($urandom)};
                4:    a = ($urandom % 2) ? 24'hFFFF00 : 24'hFFFF01;
                default: a = 24'($urandom);
            endcase
            case ($urandom % 8)
                0: f = 3'd1;
                1: f = 3'd2;
                2, 3: f = 3'd5;
                4: f = 3'd6;
                5: f = 3'd3;
                6: f = 3'd7;
                default: f = 3'd5;
            endcase
            apply(($urandom % 10) == 0, 1'($urandom), f, a, 8'($urandom), "");
        end

        done = 1'b1;
        finish_run();
    end
endmodule